// File: doc/BRIEF.md
# Wavefront Lane-Mask Divergence Sequencer

This block steps a wavefront of 64 work-items through a vector datapath that is 16 lanes wide. Every item of the wavefront runs the same instruction. A vector operation therefore goes out as four consecutive groups, one group of 16 items per clock. Each group has its own write-enable vector, taken from a 64-bit execution mask. Items whose mask bit is clear write nothing back.

Control operations let the wavefront follow a two-way branch that depends on the data. A branch operation carries one condition bit per item. The items that are active and whose condition is true run the first path. An else operation then enables the active items whose condition was false. A join operation restores the mask that held before the branch. A stack of saved masks supports nested branches. When every active item goes the same way, the block flags the empty path with a one-cycle skip pulse so that the fetch side can jump over it without spending issue cycles. Stack overflow and stack underflow each set a sticky error flag.

Top module: `wf_lane_sequencer`

## Requirements
- R1: After reset, `exec_mask` is all ones, `grp_valid`, `busy`, `path_skip`, `err_overflow` and `err_underflow` are low, and `lane_wen` is zero.
- R2: A vector operation (`op_code` 2'b00) accepted in cycle t drives `grp_valid` high in cycles t+1 to t+4 with `grp_idx` 0, 1, 2, 3 in turn. Group k covers items 16k to 16k+15, and `lane_wen` bit j belongs to item 16k+j.
- R3: `busy` is high in the first three issue cycles of a vector operation and low in the fourth. An operation presented while `busy` is high is ignored and changes neither the mask, the issue sequence nor the flags. An operation accepted in the fourth cycle begins its group 0 in the very next cycle.
- R4: In an issue cycle, `lane_wen` equals the `exec_mask` bits of the current group. Outside issue cycles, `lane_wen` is zero.
- R5: A branch (`op_code` 2'b01) sets `exec_mask` to (old mask AND `cond`) from the next cycle on. It saves the old mask and the set (old mask AND NOT `cond`) on the stack.
- R6: An else (`op_code` 2'b10) sets `exec_mask` to the saved set (pre-branch mask AND NOT `cond`) of the innermost open branch.
- R7: A join (`op_code` 2'b11) restores `exec_mask` to the mask saved by the innermost open branch and removes that entry.
- R8: `path_skip` is high for exactly the one cycle after a branch whose new mask is empty, or after an else whose new mask is empty. It is low in every other cycle.
- R9: Items that are inactive when a branch is taken stay inactive on both of its paths, including inside nested branches, until the matching join.
- R10: The stack holds 8 nested branches. A branch with 8 entries held sets `err_overflow`, which stays set until reset, and leaves the mask and the stack unchanged.
- R11: An else or join with an empty stack sets `err_underflow`, which stays set until reset, and leaves the mask unchanged.
- R12: Control operations complete in one cycle and never raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present; accepted when `busy` is low |
| op_code | input | 2 | 00 vector, 01 branch, 10 else, 11 join |
| cond | input | 64 | Per-item branch condition, used by branch |
| busy | output | 1 | Vector issue in progress; new operations ignored |
| grp_valid | output | 1 | A group of the current vector operation is issuing |
| grp_idx | output | 2 | Index of the issuing group |
| lane_wen | output | 16 | Write-back enable per lane for the issuing group |
| exec_mask | output | 64 | Current per-item active mask |
| path_skip | output | 1 | The path just entered has no active item |
| err_overflow | output | 1 | Sticky: branch attempted with a full stack |
| err_underflow | output | 1 | Sticky: else or join attempted with an empty stack |

## Verification
An accepted vector operation shows its four groups in the four cycles after the accepting edge. A control operation changes `exec_mask`, `path_skip` and the error flags one edge after it is accepted. The bench keeps a behavioural model that advances once per edge, using a queue for the stack. It compares every output at the falling edge, before it drives the next operation, so each expected value lines up with the edge that produced it. Directed checks of the mask and the flags sample 2 ns after the rising edge that follows the operation. These checks cover back-to-back issue, operations blocked while busy, uniform branches, nesting and stack limits.

// File: rtl/wf_seq_pkg.sv
package wf_seq_pkg;

    typedef enum logic [1:0] {
        OP_VECTOR = 2'b00,
        OP_BRANCH = 2'b01,
        OP_ELSE   = 2'b10,
        OP_JOIN   = 2'b11
    } wf_op_e;

endpackage

// File: rtl/wf_group_issue.sv
module wf_group_issue #(
    parameter  int GROUPS = 4,
    localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          issuing,
    output logic [GW-1:0] grp,
    output logic          busy
);

    localparam logic [GW-1:0] LAST = GW'(GROUPS - 1);

    typedef struct packed {
        logic          act;
        logic [GW-1:0] grp;
    } iss_t;

    iss_t iss_d, iss_q;

    always_comb begin
        iss_d = iss_q;
        if (iss_q.act) begin
            if (iss_q.grp == LAST) begin
                iss_d.act = 1'b0;
            end else begin
                iss_d.grp = iss_q.grp + GW'(1);
            end
        end
        if (start) begin
            iss_d.act = 1'b1;
            iss_d.grp = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iss_q <= '0;
        end else begin
            iss_q <= iss_d;
        end
    end

    assign issuing = iss_q.act;
    assign grp     = iss_q.grp;
    assign busy    = iss_q.act && (iss_q.grp != LAST);

endmodule

// File: rtl/wf_mask_stack.sv
module wf_mask_stack #(
    parameter  int W     = 64,
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_orig,
    input  logic [W-1:0] push_other,
    output logic [W-1:0] top_orig,
    output logic [W-1:0] top_other,
    output logic         empty,
    output logic         full
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [W-1:0]  orig_q  [DEPTH];
    logic [W-1:0]  other_q [DEPTH];
    logic [IW-1:0] wr_idx, rd_idx;

    assign empty  = (cnt_q == '0);
    assign full   = (cnt_q == CW'(DEPTH));
    assign wr_idx = IW'(cnt_q);
    assign rd_idx = IW'(cnt_q - CW'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (push && !full) begin
            cnt_d = cnt_q + CW'(1);
        end else if (pop && !empty) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                orig_q[e]  <= '0;
                other_q[e] <= '0;
            end
        end else if (push && !full) begin
            orig_q[wr_idx]  <= push_orig;
            other_q[wr_idx] <= push_other;
        end
    end

    assign top_orig  = orig_q[rd_idx];
    assign top_other = other_q[rd_idx];

endmodule

// File: rtl/wf_lane_sequencer.sv
module wf_lane_sequencer
    import wf_seq_pkg::*;
#(
    parameter  int ITEMS       = 64,
    parameter  int LANES       = 16,
    parameter  int STACK_DEPTH = 8,
    localparam int GROUPS      = ITEMS / LANES,
    localparam int GW          = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic [ITEMS-1:0] cond,
    output logic             busy,
    output logic             grp_valid,
    output logic [GW-1:0]    grp_idx,
    output logic [LANES-1:0] lane_wen,
    output logic [ITEMS-1:0] exec_mask,
    output logic             path_skip,
    output logic             err_overflow,
    output logic             err_underflow
);

    typedef struct packed {
        logic [ITEMS-1:0] mask;
        logic             skip;
        logic             ovf;
        logic             udf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             accept;
    logic             start;
    logic             push;
    logic             pop;
    logic [ITEMS-1:0] taken;
    logic [ITEMS-1:0] other;
    logic [ITEMS-1:0] top_orig;
    logic [ITEMS-1:0] top_other;
    logic             stk_empty;
    logic             stk_full;
    logic [LANES-1:0] slice [GROUPS];

    assign accept = op_valid && !busy;
    assign taken  = cond & ctl_q.mask;
    assign other  = ctl_q.mask & ~cond;

    wf_group_issue #(
        .GROUPS (GROUPS)
    ) u_issue (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .issuing (grp_valid),
        .grp     (grp_idx),
        .busy    (busy)
    );

    wf_mask_stack #(
        .W     (ITEMS),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .pop        (pop),
        .push_orig  (ctl_q.mask),
        .push_other (other),
        .top_orig   (top_orig),
        .top_other  (top_other),
        .empty      (stk_empty),
        .full       (stk_full)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.skip = 1'b0;
        start      = 1'b0;
        push       = 1'b0;
        pop        = 1'b0;
        if (accept) begin
            case (wf_op_e'(op_code))
                OP_VECTOR: start = 1'b1;
                OP_BRANCH: begin
                    if (stk_full) begin
                        ctl_d.ovf = 1'b1;
                    end else begin
                        push       = 1'b1;
                        ctl_d.mask = taken;
                        ctl_d.skip = ~|taken;
                    end
                end
                OP_ELSE: begin
                    if (stk_empty) begin
                        ctl_d.udf = 1'b1;
                    end else begin
                        ctl_d.mask = top_other;
                        ctl_d.skip = ~|top_other;
                    end
                end
                default: begin
                    if (stk_empty) begin
                        ctl_d.udf = 1'b1;
                    end else begin
                        ctl_d.mask = top_orig;
                        pop        = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_slice
        assign slice[g] = ctl_q.mask[g*LANES +: LANES];
    end

    assign lane_wen      = grp_valid ? slice[grp_idx] : '0;
    assign exec_mask     = ctl_q.mask;
    assign path_skip     = ctl_q.skip;
    assign err_overflow  = ctl_q.ovf;
    assign err_underflow = ctl_q.udf;

endmodule

// File: rtl/wf_seq_checker.sv
module wf_seq_checker #(
    parameter int ITEMS = 64,
    parameter int LANES = 16,
    parameter int GW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [1:0]       op_code,
    input logic             busy,
    input logic             grp_valid,
    input logic [GW-1:0]    grp_idx,
    input logic [LANES-1:0] lane_wen,
    input logic [ITEMS-1:0] exec_mask,
    input logic             path_skip,
    input logic             err_overflow,
    input logic             err_underflow
);

    localparam logic [GW-1:0] LAST = GW'(ITEMS / LANES - 1);

    a_r2_group_advance: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid && (grp_idx != LAST) |=> grp_valid && (grp_idx == $past(grp_idx) + GW'(1)));

    a_r3_busy_keeps_issuing: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> grp_valid);

    a_r3_busy_holds_mask: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(exec_mask));

    a_r4_idle_no_wen: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_valid |-> (lane_wen == '0));

    a_r5_branch_narrows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !busy && (op_code == 2'b01) |=> ((exec_mask & ~$past(exec_mask)) == '0));

    a_r8_skip_source: assert property (@(posedge clk) disable iff (!rst_n)
        path_skip |-> $past(op_valid && !busy && (op_code == 2'b01 || op_code == 2'b10)));

    a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |=> err_overflow);

    a_r11_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |=> err_underflow);

    a_r12_ctrl_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !busy && (op_code != 2'b00) |=> !busy);

endmodule

bind wf_lane_sequencer wf_seq_checker #(
    .ITEMS (ITEMS),
    .LANES (LANES),
    .GW    (GW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_code       (op_code),
    .busy          (busy),
    .grp_valid     (grp_valid),
    .grp_idx       (grp_idx),
    .lane_wen      (lane_wen),
    .exec_mask     (exec_mask),
    .path_skip     (path_skip),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow)
);

// File: tb/wf_lane_sequencer_test.sv
`timescale 1ns/1ps
module wf_lane_sequencer_test;

    localparam logic [1:0] VEC = 2'b00, BR = 2'b01, ELS = 2'b10, JN = 2'b11;
    localparam logic [63:0] ONES = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [63:0] cond = '0;
    logic        busy, grp_valid, path_skip, err_overflow, err_underflow;
    logic [1:0]  grp_idx;
    logic [15:0] lane_wen;
    logic [63:0] exec_mask;

    int nchk = 0;
    int nfail = 0;

    // behavioural reference state
    logic [63:0]  m_mask;
    logic [127:0] m_stk [$];
    bit           m_act, m_skip, m_ovf, m_udf;
    int           m_qtr;

    always #5 clk = ~clk;

    wf_lane_sequencer uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .cond(cond),
        .busy(busy), .grp_valid(grp_valid), .grp_idx(grp_idx), .lane_wen(lane_wen),
        .exec_mask(exec_mask), .path_skip(path_skip),
        .err_overflow(err_overflow), .err_underflow(err_underflow)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mask = ONES;
        m_stk.delete();
        m_act = 0; m_skip = 0; m_ovf = 0; m_udf = 0; m_qtr = 0;
    endtask

    task automatic compare();
        logic [15:0] ew;
        bit eb;
        eb = m_act && (m_qtr != 3);
        ew = m_act ? m_mask[m_qtr*16 +: 16] : 16'h0;
        chk(grp_valid === m_act, "R2 grp_valid", 64'(grp_valid), 64'(m_act));
        if (m_act) chk(grp_idx === 2'(m_qtr), "R2 grp_idx", 64'(grp_idx), 64'(m_qtr));
        chk(busy === eb, "R3 busy", 64'(busy), 64'(eb));
        chk(lane_wen === ew, "R4 lane_wen", 64'(lane_wen), 64'(ew));
        chk(exec_mask === m_mask, "R5 R6 R7 exec_mask", exec_mask, m_mask);
        chk(path_skip === m_skip, "R8 path_skip", 64'(path_skip), 64'(m_skip));
        chk(err_overflow === m_ovf, "R10 err_overflow", 64'(err_overflow), 64'(m_ovf));
        chk(err_underflow === m_udf, "R11 err_underflow", 64'(err_underflow), 64'(m_udf));
    endtask

    task automatic step(input bit v, input logic [1:0] op, input logic [63:0] c);
        bit acc;
        bit nskip;
        @(negedge clk);
        compare();
        op_valid = v; op_code = op; cond = c;
        acc = v && !(m_act && (m_qtr != 3));
        nskip = 0;
        if (m_act) begin
            if (m_qtr == 3) m_act = 0;
            else m_qtr++;
        end
        if (acc) begin
            case (op)
                VEC: begin m_act = 1; m_qtr = 0; end
                BR: begin
                    if (m_stk.size() == 8) m_ovf = 1;
                    else begin
                        m_stk.push_back({m_mask, m_mask & ~c});
                        m_mask = m_mask & c;
                        nskip = (m_mask == '0);
                    end
                end
                ELS: begin
                    if (m_stk.size() == 0) m_udf = 1;
                    else begin
                        m_mask = m_stk[$][63:0];
                        nskip = (m_mask == '0);
                    end
                end
                default: begin
                    if (m_stk.size() == 0) m_udf = 1;
                    else begin
                        m_mask = m_stk[$][127:64];
                        void'(m_stk.pop_back());
                    end
                end
            endcase
        end
        m_skip = nskip;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, VEC, '0);
    endtask

    // sample directly after the edge that follows the last operation
    task automatic expect_mask(input logic [63:0] exp, input string tag);
        #2;
        chk(exec_mask === exp, tag, exec_mask, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; op_valid = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] a, b;
        a = 64'hF0F0_0F0F_FF00_00FF;
        b = 64'hAAAA_5555_CCCC_3333;
        do_reset();
        #1;
        // R1 reset state
        chk(exec_mask === ONES, "R1 mask", exec_mask, ONES);
        chk({grp_valid, busy, path_skip, err_overflow, err_underflow} === 5'b0,
            "R1 flags", 64'({grp_valid, busy, path_skip, err_overflow, err_underflow}), 64'h0);
        chk(lane_wen === 16'h0, "R1 lane_wen", 64'(lane_wen), 64'h0);

        // R2 full-mask vector issue
        step(1, VEC, '0);
        idle(5);

        // R5 branch, then R3: three ignored operations while busy, back-to-back vector
        step(1, BR, a);
        expect_mask(a, "R5 taken mask");
        step(1, VEC, '0);
        step(1, BR, '0);
        step(1, JN, '0);
        step(1, ELS, '0);
        step(1, VEC, '0);
        idle(5);
        expect_mask(a, "R3 mask unchanged by blocked ops");
        step(1, ELS, '0);
        expect_mask(~a, "R6 else mask");
        step(1, VEC, '0);
        idle(4);
        step(1, JN, '0);
        expect_mask(ONES, "R7 join restores");

        // R9 nesting keeps inactive items off
        step(1, BR, a);
        step(1, BR, b);
        expect_mask(a & b, "R9 inner taken");
        step(1, ELS, '0);
        expect_mask(a & ~b, "R9 inner else");
        step(1, VEC, '0);
        idle(4);
        step(1, JN, '0);
        expect_mask(a, "R9 inner join");
        step(1, ELS, '0);
        step(1, JN, '0);

        // R8 uniform branches
        step(1, BR, '0);
        #2 chk(path_skip === 1'b1, "R8 skip on all-false", 64'(path_skip), 64'h1);
        step(1, ELS, '0);
        #2 chk(path_skip === 1'b0, "R8 no skip on full else", 64'(path_skip), 64'h0);
        step(1, JN, '0);
        step(1, BR, ONES);
        #2 chk(path_skip === 1'b0, "R8 no skip on all-true", 64'(path_skip), 64'h0);
        step(1, ELS, '0);
        #2 chk(path_skip === 1'b1, "R8 skip on empty else", 64'(path_skip), 64'h1);
        step(1, JN, '0);
        idle(2);

        // R10 overflow, R11 underflow
        for (int i = 0; i < 8; i++) step(1, BR, ~(64'h1 << i));
        step(1, BR, 64'h0);
        #2 chk(err_overflow === 1'b1, "R10 overflow flag", 64'(err_overflow), 64'h1);
        expect_mask(64'hFFFF_FFFF_FFFF_FF00, "R10 mask kept on overflow");
        for (int i = 0; i < 8; i++) step(1, JN, '0);
        expect_mask(ONES, "R10 eight levels unwound");
        step(1, ELS, '0);
        #2 chk(err_underflow === 1'b1, "R11 underflow flag", 64'(err_underflow), 64'h1);
        step(1, JN, '0);
        expect_mask(ONES, "R11 mask kept on underflow");
        idle(3);

        // R12 and mixed traffic, checked every cycle against the model
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [1:0] op;
            r = int'($urandom_range(0, 9));
            op = (r < 4) ? VEC : (r < 6) ? BR : (r < 8) ? ELS : JN;
            step($urandom_range(0, 3) != 0, op, {$urandom, $urandom} | {$urandom, $urandom});
        end
        idle(6);
        finish_run();
    end

endmodule